// File: doc/BRIEF.md
# Bob Field-to-Frame Deinterlacer

This block takes a video stream with one pixel per beat, carrying either interlaced fields or progressive frames, and always produces progressive frames. For an interlaced field, each field line is sent to its own place in a frame of twice the field height. Every line between two field lines is the rounded average of the field line directly above it and the field line directly below it. When a line has only one field neighbour, at the top or bottom edge, that neighbour is copied. When the input is marked as progressive, each frame passes through unchanged.

Four configuration inputs set the field width, the field height, an interlaced flag and a field-selection mode. The mode decides which field types are deinterlaced and which are dropped. If both types are kept and the input alternates between them, the block produces one frame per field. If only one type is kept, the output frame rate is half the input field rate. The block reads the parity of each field from a sideband user bit on its first beat. A single line store, sized by a parameter, holds the most recent field line. Each output line that comes from that store is replayed while the input is held off.

Top module: `bobDeint`

## Requirements
- R1: For a kept interlaced field of width W and height H, the output is 2H lines of W beats each. mTuser is 1 only on the first beat of the frame, and mTlast is 1 only on the last beat of each line.
- R2: The lines of a field with parity 0 (F0) appear on output lines 0, 2, 4 and so on, in field order. The lines of a field with parity 1 (F1) appear on output lines 1, 3, 5 and so on.
- R3: An output line that lies between field lines k and k+1 has the sample (a + b + 1) >> 1 at each column, where a and b are the samples of those two field lines in that column.
- R4: For F0, output line 2H-1 is a copy of field line H-1. For F1, output line 0 is a copy of field line 0.
- R5: cfgMode 2'b00 keeps only F0, 2'b01 keeps only F1, and 2'b10 or 2'b11 keeps both. A field whose type is rejected has all of its beats accepted and produces no output beat.
- R6: When cfgInterlaced is 0, every frame of cfgHeight lines passes through unchanged. Data, first-beat marking and line ends are the same as the input, whatever the mode or the parity bit.
- R7: A field or frame starts at the input beat with sTuser[0]=1, and sTuser[1] of that beat is its parity. Input beats that arrive while no field is open and that have sTuser[0]=0 are accepted and produce no output.
- R8: The configuration inputs are sampled only when a field starts. A change to them during a field does not alter that field's output.
- R9: An output beat that is not accepted keeps its data, mTuser and mTlast until mTready is 1. No input beat is accepted while a line is being emitted from the line store.
- R10: After reset, mTvalid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWidth | input | $clog2(MAX_W+1) | Pixels per line, 1..MAX_W |
| cfgHeight | input | $clog2(MAX_H+1) | Lines per field or frame, at least 1 |
| cfgInterlaced | input | 1 | 1: the input is fields; 0: the input is progressive |
| cfgMode | input | 2 | Field selection (R5) |
| sTdata | input | PIX_W | Input pixel |
| sTvalid | input | 1 | Input beat valid |
| sTready | output | 1 | Input beat accepted |
| sTuser | input | 2 | Bit 0: first beat; bit 1: field parity |
| sTlast | input | 1 | Last beat of the input line |
| mTdata | output | PIX_W | Output pixel |
| mTvalid | output | 1 | Output beat valid |
| mTready | input | 1 | Downstream ready |
| mTuser | output | 1 | First beat of the output frame |
| mTlast | output | 1 | Last beat of the output line |

## Verification
The inputs are a mix of random fields of both parities and directed cases. The random fields vary the width, the height, the mode and the interlaced flag, and the samples are random. Fields of height 1 and width 1 exercise the edge-copy rule apart from the interpolation rule. Full-scale samples (0, 1, 254, 255) in alternating lines show whether the rounding adds one before the shift. Dropped fields, progressive frames, stray beats before the first beat of a field, and configuration changes during a field show that each of these leaves the output as predicted. Heavy random backpressure on the output, combined with gaps on the input, exposes any replayed beat that is lost or repeated.

// File: rtl/bobPkg.sv
package bobPkg;
  typedef enum logic [1:0] {SEL_PASS, SEL_AVG, SEL_BUF} selT;
  typedef enum logic [1:0] {ST_IDLE, ST_STREAM, ST_REPLAY} stateT;
  typedef struct packed {
    logic wrEn;
    selT  sel;
  } ctlStrbT;
endpackage

// File: rtl/bobDp.sv
module bobDp import bobPkg::*; #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64,
  localparam int COLW = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic [COLW-1:0]  col,
  input  ctlStrbT          strb,
  input  logic [PIX_W-1:0] sTdata,
  output logic [PIX_W-1:0] mTdata
);
  logic [PIX_W-1:0] lineBuf [MAX_W];
  logic [PIX_W-1:0] prevPix;
  logic [PIX_W:0]   sumPix;

  always_ff @(posedge clk) begin
    if (strb.wrEn) lineBuf[col] <= sTdata;
  end

  // old value is read in the same cycle that the new one is written
  assign prevPix = lineBuf[col];
  assign sumPix  = {1'b0, prevPix} + {1'b0, sTdata} + {{PIX_W{1'b0}}, 1'b1};

  always_comb begin
    case (strb.sel)
      SEL_AVG: mTdata = sumPix[PIX_W:1];
      SEL_BUF: mTdata = prevPix;
      default: mTdata = sTdata;
    endcase
  end
endmodule

// File: rtl/bobCtl.sv
module bobCtl import bobPkg::*; #(
  parameter int MAX_W = 64,
  parameter int MAX_H = 1080,
  localparam int COLW = $clog2(MAX_W),
  localparam int WW   = $clog2(MAX_W + 1),
  localparam int HW   = $clog2(MAX_H + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [WW-1:0]   cfgWidth,
  input  logic [HW-1:0]   cfgHeight,
  input  logic            cfgInterlaced,
  input  logic [1:0]      cfgMode,
  input  logic            sTvalid,
  input  logic [1:0]      sTuser,
  output logic            sTready,
  output logic            mTvalid,
  input  logic            mTready,
  output logic            mTuser,
  output logic            mTlast,
  output logic [COLW-1:0] col,
  output ctlStrbT         strb
);
  stateT           state;
  logic [COLW-1:0] colQ;
  logic [HW-1:0]   lineQ, hgtQ;
  logic [WW-1:0]   widQ;
  logic [1:0]      repQ, repsC;
  logic            interQ, showQ, oddQ;
  logic            lastCol, lastLine, inTake;

  assign lastCol  = (WW'(colQ) == widQ - WW'(1));
  assign lastLine = (lineQ == hgtQ - HW'(1));
  assign col      = colQ;

  // number of lines replayed from the store after the current field line
  always_comb begin
    if (!showQ || !interQ) repsC = 2'd0;
    else if (oddQ)         repsC = 2'd1;
    else                   repsC = {1'b0, lineQ != '0} + {1'b0, lastLine};
  end

  always_comb begin
    sTready   = 1'b0;
    mTvalid   = 1'b0;
    mTuser    = 1'b0;
    mTlast    = lastCol;
    strb.wrEn = 1'b0;
    strb.sel  = SEL_PASS;
    case (state)
      ST_IDLE:   sTready = !sTuser[0];
      ST_STREAM: begin
        sTready   = showQ ? mTready : 1'b1;
        mTvalid   = showQ && sTvalid;
        mTuser    = (lineQ == '0) && (colQ == '0);
        strb.sel  = (interQ && lineQ != '0) ? SEL_AVG : SEL_PASS;
        strb.wrEn = sTvalid && sTready;
      end
      default: begin
        mTvalid  = 1'b1;
        strb.sel = SEL_BUF;
      end
    endcase
  end

  assign inTake = sTvalid && sTready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      colQ   <= '0;
      lineQ  <= '0;
      repQ   <= '0;
      widQ   <= WW'(1);
      hgtQ   <= HW'(1);
      interQ <= 1'b0;
      showQ  <= 1'b0;
      oddQ   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (sTvalid && sTuser[0]) begin
          widQ   <= cfgWidth;
          hgtQ   <= cfgHeight;
          interQ <= cfgInterlaced;
          oddQ   <= sTuser[1];
          showQ  <= !cfgInterlaced || cfgMode[1] || (cfgMode[0] == sTuser[1]);
          colQ   <= '0;
          lineQ  <= '0;
          state  <= ST_STREAM;
        end
        ST_STREAM: if (inTake) begin
          if (lastCol) begin
            colQ <= '0;
            if (repsC != 2'd0) begin
              repQ  <= repsC;
              state <= ST_REPLAY;
            end else if (lastLine) begin
              state <= ST_IDLE;
            end else begin
              lineQ <= lineQ + HW'(1);
            end
          end else begin
            colQ <= colQ + COLW'(1);
          end
        end
        default: if (mTready) begin
          if (lastCol) begin
            colQ <= '0;
            repQ <= repQ - 2'd1;
            if (repQ == 2'd1) begin
              if (lastLine) state <= ST_IDLE;
              else begin
                lineQ <= lineQ + HW'(1);
                state <= ST_STREAM;
              end
            end
          end else begin
            colQ <= colQ + COLW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bobDeint.sv
module bobDeint import bobPkg::*; #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64,
  parameter int MAX_H = 1080,
  localparam int COLW = $clog2(MAX_W),
  localparam int WW   = $clog2(MAX_W + 1),
  localparam int HW   = $clog2(MAX_H + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WW-1:0]    cfgWidth,
  input  logic [HW-1:0]    cfgHeight,
  input  logic             cfgInterlaced,
  input  logic [1:0]       cfgMode,
  input  logic [PIX_W-1:0] sTdata,
  input  logic             sTvalid,
  output logic             sTready,
  input  logic [1:0]       sTuser,
  input  logic             sTlast,
  output logic [PIX_W-1:0] mTdata,
  output logic             mTvalid,
  input  logic             mTready,
  output logic             mTuser,
  output logic             mTlast
);
  ctlStrbT         ctlStrb;
  logic [COLW-1:0] colIdx;

  bobCtl #(.MAX_W(MAX_W), .MAX_H(MAX_H)) u_ctl (
    .clk(clk), .rstN(rstN),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .cfgInterlaced(cfgInterlaced), .cfgMode(cfgMode),
    .sTvalid(sTvalid), .sTuser(sTuser), .sTready(sTready),
    .mTvalid(mTvalid), .mTready(mTready), .mTuser(mTuser), .mTlast(mTlast),
    .col(colIdx), .strb(ctlStrb)
  );

  bobDp #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_dp (
    .clk(clk), .col(colIdx), .strb(ctlStrb),
    .sTdata(sTdata), .mTdata(mTdata)
  );
endmodule

// File: rtl/bobDeintChk.sv
module bobDeintChk import bobPkg::*; #(
  parameter int PIX_W = 8,
  parameter int MAX_W = 64,
  localparam int CW = $clog2(MAX_W + 1) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             sTvalid,
  input logic             sTready,
  input logic             sTlast,
  input logic [PIX_W-1:0] sTdata,
  input logic             mTvalid,
  input logic             mTready,
  input logic [PIX_W-1:0] mTdata,
  input logic             mTuser,
  input logic             mTlast,
  input ctlStrbT          strb
);
  logic [CW-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else if (mTvalid && mTready) beatCnt <= mTlast ? '0 : beatCnt + CW'(1);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && !mTready |=> mTvalid && $stable(mTdata) && $stable(mTuser) && $stable(mTlast)); // R9
  AST_REPLAY_NO_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    strb.sel == SEL_BUF |-> !sTready); // R9
  AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && strb.sel == SEL_PASS |-> mTdata == sTdata); // R6
  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid |-> beatCnt < CW'(MAX_W)); // R1
  AST_SOF_AT_LINE_START: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && mTuser |-> beatCnt == '0); // R1
  AST_LAST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid && sTvalid && sTready && strb.sel != SEL_BUF |-> mTlast == sTlast); // R1
endmodule

bind bobDeint bobDeintChk #(.PIX_W(PIX_W), .MAX_W(MAX_W)) u_chk (
  .clk(clk), .rstN(rstN), .sTvalid(sTvalid), .sTready(sTready),
  .sTlast(sTlast), .sTdata(sTdata), .mTvalid(mTvalid), .mTready(mTready),
  .mTdata(mTdata), .mTuser(mTuser), .mTlast(mTlast), .strb(ctlStrb)
);

// File: tb/bobDeint_tb.sv
`timescale 1ns/1ps
module bobDeint_tb;
  localparam int PIX_W = 8;
  localparam int MAX_W = 64;
  localparam int MAX_H = 1080;
  localparam int WW = $clog2(MAX_W + 1);
  localparam int HW = $clog2(MAX_H + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WW-1:0] cfgWidth = WW'(4);
  logic [HW-1:0] cfgHeight = HW'(2);
  logic cfgInterlaced = 1'b1;
  logic [1:0] cfgMode = 2'b10;
  logic [PIX_W-1:0] sTdata = '0;
  logic sTvalid = 1'b0;
  logic sTready;
  logic [1:0] sTuser = 2'b00;
  logic sTlast = 1'b0;
  logic [PIX_W-1:0] mTdata;
  logic mTvalid;
  logic mTready = 1'b1;
  logic mTuser, mTlast;

  always #2.5 clk = ~clk;

  bobDeint #(.PIX_W(PIX_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_dut (.*);

  int total = 0;
  int bad = 0;
  int readyPct = 100;
  int gapPct = 0;
  int pix [0:MAX_W*8-1];
  logic [PIX_W+1:0] outQ [$];
  logic [PIX_W+1:0] expQ [$];

  always @(posedge clk) begin
    #1;
    mTready = (($urandom % 100) < readyPct);
  end

  always @(negedge clk)
    if (rstN && mTvalid && mTready) outQ.push_back({mTuser, mTlast, mTdata});

  initial begin
    #(150000 * 5);
    total++; bad++;
    $display("FAIL watchdog: run hung, got %0d expected completion", total);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int px(int k, int x, int w);
    return pix[k * w + x];
  endfunction

  function automatic int avg2(int a, int b);
    return (a + b + 1) >> 1;
  endfunction

  // expected output from the requirements (R1-style framing, R2 placement, R3 rounding, R4 edges)
  task automatic buildExp(int w, int h, bit inter, logic [1:0] mode, bit odd);
    bit keep;
    int v;
    expQ.delete();
    keep = !inter || mode[1] || (mode[0] == odd);
    if (!keep) return;
    for (int j = 0; j < (inter ? 2 * h : h); j++)
      for (int x = 0; x < w; x++) begin
        if (!inter) v = px(j, x, w);
        else if (!odd) begin
          if (j % 2 == 0) v = px(j / 2, x, w);
          else if ((j - 1) / 2 + 1 < h) v = avg2(px((j - 1) / 2, x, w), px((j - 1) / 2 + 1, x, w));
          else v = px((j - 1) / 2, x, w);
        end else begin
          if (j % 2 == 1) v = px((j - 1) / 2, x, w);
          else if (j == 0) v = px(0, x, w);
          else v = avg2(px(j / 2 - 1, x, w), px(j / 2, x, w));
        end
        expQ.push_back({(j == 0 && x == 0), (x == w - 1), PIX_W'(v)});
      end
  endtask

  task automatic putBeat(logic [PIX_W-1:0] d, logic [1:0] u, logic l);
    while (($urandom % 100) < gapPct) @(posedge clk) #1;
    sTdata = d; sTuser = u; sTlast = l; sTvalid = 1'b1;
    forever begin
      @(negedge clk);
      if (sTready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    sTvalid = 1'b0;
  endtask

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // pat 0 random, 1 full-scale extremes
  task automatic runField(string tag, int w, int h, bit inter, logic [1:0] mode, bit odd,
                          int junk, bit midChange, int pat);
    int lines, waitC, firstBad;
    lines = h;
    for (int i = 0; i < w * h; i++)
      pix[i] = (pat == 1) ? (((i / w) % 2 == 0) ? ((i % 2) ? 255 : 0) : ((i % 2) ? 254 : 1))
                          : int'($urandom % 256);
    cfgWidth = WW'(w); cfgHeight = HW'(h); cfgInterlaced = inter; cfgMode = mode;
    buildExp(w, h, inter, mode, odd);
    outQ.delete();
    for (int i = 0; i < junk; i++) putBeat(PIX_W'($urandom), {1'b1, 1'b0}, 1'b0);
    for (int k = 0; k < lines; k++)
      for (int x = 0; x < w; x++) begin
        putBeat(PIX_W'(px(k, x, w)), {odd, (k == 0 && x == 0)}, (x == w - 1));
        if (midChange && k == 0 && x == 0) begin
          cfgWidth = WW'(w + 3); cfgHeight = HW'(h + 2);
          cfgInterlaced = !inter; cfgMode = ~mode;
        end
      end
    waitC = 0;
    while (outQ.size() < expQ.size() && waitC < 20000) begin
      @(posedge clk); waitC++;
    end
    repeat (6) @(posedge clk);
    #1;
    check(outQ.size() == expQ.size(), {tag, " beat count"}, outQ.size(), expQ.size());
    firstBad = -1;
    for (int i = 0; i < expQ.size() && i < outQ.size(); i++)
      if (firstBad < 0 && outQ[i] !== expQ[i]) firstBad = i;
    if (firstBad >= 0)
      check(1'b0, {tag, " beat content"}, int'(outQ[firstBad]), int'(expQ[firstBad]));
    else
      check(1'b1, {tag, " beat content"}, 0, 0);
  endtask

  initial begin
    int unsigned seedV;
    seedV = $urandom(32'd2024);
    repeat (4) @(posedge clk);
    #1;
    check(mTvalid == 1'b0, "R10 valid low in reset", mTvalid, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(mTvalid == 1'b0, "R10 valid low after reset", mTvalid, 0);

    // directed corners
    runField("R1 R2 R3 F0 both", 5, 4, 1, 2'b10, 0, 0, 0, 0);
    runField("R2 R3 R4 F1 both", 5, 4, 1, 2'b11, 1, 0, 0, 0);
    runField("R3 rounding extremes F0", 8, 4, 1, 2'b10, 0, 0, 0, 1);
    runField("R3 rounding extremes F1", 8, 4, 1, 2'b10, 1, 0, 0, 1);
    runField("R4 height one F0", 6, 1, 1, 2'b00, 0, 0, 0, 0);
    runField("R4 height one F1", 6, 1, 1, 2'b01, 1, 0, 0, 0);
    runField("R4 width one", 1, 3, 1, 2'b10, 0, 0, 0, 0);
    runField("R1 full width", MAX_W, 2, 1, 2'b10, 1, 0, 0, 0);
    runField("R5 mode00 drops F1", 4, 3, 1, 2'b00, 1, 0, 0, 0);
    runField("R5 mode00 keeps F0", 4, 3, 1, 2'b00, 0, 0, 0, 0);
    runField("R5 mode01 drops F0", 4, 3, 1, 2'b01, 0, 0, 0, 0);
    runField("R5 mode01 keeps F1", 4, 3, 1, 2'b01, 1, 0, 0, 0);
    runField("R6 progressive pass", 7, 5, 0, 2'b00, 1, 0, 0, 0);
    runField("R7 stray beats ignored", 4, 2, 1, 2'b10, 0, 3, 0, 0);
    runField("R8 mid-field cfg change", 6, 3, 1, 2'b10, 1, 0, 1, 0);
    runField("R8 mid-field cfg change prog", 6, 3, 0, 2'b01, 0, 0, 1, 0);
    readyPct = 35; gapPct = 30;
    runField("R9 backpressure F0", 9, 5, 1, 2'b10, 0, 0, 0, 0);
    runField("R9 backpressure F1", 9, 5, 1, 2'b10, 1, 0, 0, 0);

    // constrained random mix
    for (int n = 0; n < 60; n++) begin
      readyPct = 40 + int'($urandom % 61);
      gapPct = int'($urandom % 40);
      runField("R1 R2 R3 R5 R6 random", 1 + int'($urandom % 16), 1 + int'($urandom % 6),
               ($urandom % 4) != 0, 2'($urandom), n % 2 == 1, int'($urandom % 2), 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule